// File: doc/BRIEF.md
# DMA Source Address Generator

This block produces the source address for each channel of a four-channel DMA engine. Software programs two registers per channel over a simple write/read port. One holds a 31-bit start address. The other is a two-bit control word: one bit says which bus the source lives on, and the other says whether the address steps forward or stays fixed.

Each channel keeps a working address counter. The counter takes the start address when it is zero and the channel's acknowledge is high. After that, every completed beat advances it by the transfer size: one, two or four bytes.

In fixed mode a single transfer leaves the address where it is. A four-beat burst in fixed mode still walks through consecutive addresses, and after its last beat the counter returns to the address the burst began at.

The block has no streaming data path, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal. The beat strobe is taken on the edge where it is high, and the block never stalls it.

Top module: `dma_src_addr_gen`

## Requirements
- R1: After reset every start address, control word, working address and beat position is zero, so every `src_addr` slice and every `src_on_periph` bit reads 0.
- R2: The register map uses a 0x40-byte stride per channel; the channel number is `reg_addr[7:6]` and the in-channel offset is `reg_addr[5:0]`.
  - Offset 0x00 holds the start address in bits 30:0.
  - Offset 0x04 holds the control word in bits 1:0.
  - Unused upper bits are dropped on write and read back as zero.
- R3: A write to any in-channel offset other than 0x00 and 0x04 changes no register, and reading such an offset returns zero.
- R4: When a channel's working address is zero and its `dma_ack` bit is high, the next edge loads that channel's start address and clears its beat position. A load takes priority over a beat in the same cycle. A non-zero working address is never reloaded.
- R5: `src_on_periph[n]` equals bit 1 of channel n's control word (0 = system bus, 1 = peripheral bus).
- R6: With control bit 0 clear, each beat adds the step for `data_size` to the working address, wrapping at 31 bits. The steps are: code 00 adds 1, 01 adds 2, 10 adds 4, and the reserved code 11 adds 4.
- R7: With control bit 0 set and `burst_mode` low, a beat leaves the working address unchanged.
- R8: With control bit 0 set and `burst_mode` high, beats 1 to 3 of a four-beat burst add the step. The fourth beat restores the address the burst started at.
- R9: With control bit 0 clear in burst mode, the address keeps climbing across burst boundaries. The beat position clears after every fourth beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (channel in bits 7:6) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| dma_ack | input | 4 | Per-channel acknowledge, gates the start-address load |
| beat_done | input | 4 | Per-channel strobe marking one completed beat |
| burst_mode | input | 4 | Per-channel burst select (0 = single beat, 1 = four-beat burst) |
| data_size | input | 8 | Two-bit transfer size per channel, channel n in bits 2n+1:2n |
| src_addr | output | 124 | Working source address per channel, channel n in bits 31n+30:31n |
| src_on_periph | output | 4 | Per-channel bus select for the current source |

## Verification
Loads and beat advances appear on `src_addr` one edge after the cycle that carries `dma_ack` or `beat_done`. Register writes take effect one edge after `reg_wr`. Register reads and `src_on_periph` are combinational and valid in the same cycle. The bench drives stimulus at a falling edge and lets exactly one rising edge pass. It then queues the expected address and bus flag, and a monitor compares them at the next falling edge, so each result is sampled in the cycle it is due.

// File: rtl/dma_src_pkg.sv
`timescale 1ns/1ps
package dma_src_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xfer_size_e;

  localparam int          OFF_W     = 6;
  localparam logic [5:0]  OFF_START = 6'h00;
  localparam logic [5:0]  OFF_CTRL  = 6'h04;
  localparam int          CTRL_W    = 2;

  // Byte step for one beat; the reserved code behaves as a word.
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_BYTE: size_step = 3'd1;
      SZ_HALF: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_src_regs.sv
`timescale 1ns/1ps
module dma_src_regs
  import dma_src_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 31,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int RA_W  = CH_W + OFF_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [RA_W-1:0]            addr,
  input  logic [31:0]                wdata,
  output logic [31:0]                rdata,
  output logic [NUM_CH*ADDR_W-1:0]   start_o,
  output logic [NUM_CH*CTRL_W-1:0]   ctrl_o
);

  logic [ADDR_W-1:0] start_q [NUM_CH];
  logic [CTRL_W-1:0] ctrl_q  [NUM_CH];
  logic [CH_W-1:0]   sel_ch;
  logic [OFF_W-1:0]  sel_off;
  logic              unused_wbits;

  assign sel_ch       = addr[RA_W-1:OFF_W];
  assign sel_off      = addr[OFF_W-1:0];
  assign unused_wbits = ^wdata[31:ADDR_W];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q[c] <= '0;
        ctrl_q[c]  <= '0;
      end else if (wr_en && sel_ch == CH_W'(c)) begin
        if (sel_off == OFF_START) start_q[c] <= wdata[ADDR_W-1:0];
        if (sel_off == OFF_CTRL)  ctrl_q[c]  <= wdata[CTRL_W-1:0];
      end
    end
    assign start_o[c*ADDR_W +: ADDR_W] = start_q[c];
    assign ctrl_o[c*CTRL_W +: CTRL_W]  = ctrl_q[c];
  end

  always_comb begin
    case (sel_off)
      OFF_START: rdata = 32'(start_q[sel_ch]);
      OFF_CTRL:  rdata = 32'(ctrl_q[sel_ch]);
      default:   rdata = '0;
    endcase
  end

  // R3
  undef_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_off != OFF_START && sel_off != OFF_CTRL)
      |=> ($stable(start_o) && $stable(ctrl_o)));

endmodule

// File: rtl/dma_src_chan.sv
`timescale 1ns/1ps
module dma_src_chan
  import dma_src_pkg::*;
#(
  parameter int ADDR_W    = 31,
  parameter int BURST_LEN = 4,
  localparam int CNT_W    = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              fixed_mode,
  input  logic              ack,
  input  logic              beat_done,
  input  logic              burst_mode,
  input  logic [1:0]        data_size,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] cur_q, cur_d, base_q, base_d, step, restore;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              load, first_beat, last_beat;

  always_comb begin
    step       = ADDR_W'(size_step(data_size));
    load       = (cur_q == '0) && ack;
    first_beat = (cnt_q == '0);
    last_beat  = burst_mode && (cnt_q == CNT_W'(BURST_LEN - 1));
    restore    = first_beat ? cur_q : base_q;
    cur_d      = cur_q;
    base_d     = base_q;
    cnt_d      = cnt_q;
    if (load) begin
      cur_d = start_addr;
      cnt_d = '0;
    end else if (beat_done) begin
      if (burst_mode) begin
        if (first_beat) base_d = cur_q;
        cnt_d = last_beat ? '0 : cnt_q + 1'b1;
      end else begin
        cnt_d = '0;
      end
      if (!fixed_mode)                    cur_d = cur_q + step;
      else if (burst_mode && !last_beat)  cur_d = cur_q + step;
      else if (burst_mode)                cur_d = restore;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      cur_q  <= cur_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign addr_o = cur_q;

  // R4
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_o == '0 && ack) |=> (addr_o == $past(start_addr)));

  // R6
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !fixed_mode && addr_o != '0)
      |=> (addr_o == $past(addr_o) + ADDR_W'(size_step($past(data_size)))));

  // R7
  fixed_single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && fixed_mode && !burst_mode && addr_o != '0) |=> $stable(addr_o));

  // R8
  fixed_burst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !load && fixed_mode && last_beat) |=> (addr_o == $past(base_q)));

endmodule

// File: rtl/dma_src_addr_gen.sv
`timescale 1ns/1ps
module dma_src_addr_gen
  import dma_src_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 31,
  parameter int BURST_LEN = 4,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int RA_W     = CH_W + OFF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [NUM_CH-1:0]        dma_ack,
  input  logic [NUM_CH-1:0]        beat_done,
  input  logic [NUM_CH-1:0]        burst_mode,
  input  logic [2*NUM_CH-1:0]      data_size,
  output logic [NUM_CH*ADDR_W-1:0] src_addr,
  output logic [NUM_CH-1:0]        src_on_periph
);

  logic [NUM_CH*ADDR_W-1:0] start_flat;
  logic [NUM_CH*CTRL_W-1:0] ctrl_flat;

  dma_src_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .start_o (start_flat),
    .ctrl_o  (ctrl_flat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dma_src_chan #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_addr (start_flat[c*ADDR_W +: ADDR_W]),
      .fixed_mode (ctrl_flat[c*CTRL_W]),
      .ack        (dma_ack[c]),
      .beat_done  (beat_done[c]),
      .burst_mode (burst_mode[c]),
      .data_size  (data_size[2*c +: 2]),
      .addr_o     (src_addr[c*ADDR_W +: ADDR_W])
    );
    assign src_on_periph[c] = ctrl_flat[c*CTRL_W + 1];
  end

  // R5
  bus_sel_follows_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr[OFF_W-1:0] == OFF_CTRL)
      |=> (src_on_periph[$past(reg_addr[RA_W-1:OFF_W])] == $past(reg_wdata[1])));

endmodule

// File: tb/test_dma_src_addr_gen.sv
`timescale 1ns/1ps
module test_dma_src_addr_gen;
  localparam int NCH = 4;
  localparam int AW  = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              reg_wr;
  logic [7:0]        reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic [NCH-1:0]    dma_ack, beat_done, burst_mode, src_on_periph;
  logic [2*NCH-1:0]  data_size;
  logic [NCH*AW-1:0] src_addr;

  dma_src_addr_gen i_dma_src_addr_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_ack(dma_ack),
    .beat_done(beat_done), .burst_mode(burst_mode), .data_size(data_size),
    .src_addr(src_addr), .src_on_periph(src_on_periph)
  );

  int checks = 0;
  int fails  = 0;

  typedef struct {
    int          ch;
    logic [AW-1:0] addr;
    logic        periph;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [AW-1:0] m_start [NCH];
  logic [AW-1:0] m_cur   [NCH];
  logic [AW-1:0] m_base  [NCH];
  logic [1:0]    m_ctrl  [NCH];
  int            m_cnt   [NCH];

  function automatic void check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // Monitor: compare queued expectations at the falling edge after the update.
  exp_t e;
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      e = sb.pop_front();
      check(e.tag, 32'(src_addr[e.ch*AW +: AW]), 32'(e.addr));
      check(e.tag, 32'(src_on_periph[e.ch]), 32'(e.periph));
    end
  end

  function automatic logic [31:0] reg_model(logic [7:0] a);
    int c = int'(a[7:6]);
    if (a[5:0] == 6'h00) return 32'(m_start[c]);
    if (a[5:0] == 6'h04) return 32'(m_ctrl[c]);
    return 32'h0;
  endfunction

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    int c = int'(a[7:6]);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
    if (a[5:0] == 6'h00) m_start[c] = d[AW-1:0];
    if (a[5:0] == 6'h04) m_ctrl[c]  = d[1:0];
  endtask

  task automatic reg_check(logic [7:0] a, string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, reg_model(a));
  endtask

  function automatic logic [AW-1:0] step_of(logic [1:0] sz);
    return (sz == 2'b00) ? AW'(1) : (sz == 2'b01) ? AW'(2) : AW'(4);
  endfunction

  // Driver: one cycle of channel activity, then queue the expected result.
  task automatic cycle(int ch, logic ack, logic beat, logic [1:0] sz, logic bm, string tag);
    exp_t x;
    bit last;
    @(negedge clk);
    dma_ack[ch] = ack; beat_done[ch] = beat;
    data_size[2*ch +: 2] = sz; burst_mode[ch] = bm;
    @(posedge clk); #1;
    dma_ack = '0; beat_done = '0;
    if (m_cur[ch] == '0 && ack) begin
      m_cur[ch] = m_start[ch];
      m_cnt[ch] = 0;
    end else if (beat) begin
      last = bm && (m_cnt[ch] == 3);
      if (bm && m_cnt[ch] == 0) m_base[ch] = m_cur[ch];
      if (!m_ctrl[ch][0] || (bm && !last)) m_cur[ch] = m_cur[ch] + step_of(sz);
      else if (bm) m_cur[ch] = m_base[ch];
      m_cnt[ch] = (bm && !last) ? m_cnt[ch] + 1 : 0;
    end
    x.ch = ch; x.addr = m_cur[ch]; x.periph = m_ctrl[ch][1]; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dma_ack = '0; beat_done = '0; burst_mode = '0; data_size = '0;
    for (int c = 0; c < NCH; c++) begin
      m_start[c] = '0; m_cur[c] = '0; m_base[c] = '0; m_ctrl[c] = '0; m_cnt[c] = 0;
    end
    repeat (3) @(posedge clk);
    // R1: reset state
    @(negedge clk);
    check("R1 src_addr", src_addr[31:0], 32'h0);
    check("R1 src_addr hi", 32'(src_addr[NCH*AW-1:32]), 32'h0);
    check("R1 periph", 32'(src_on_periph), 32'h0);
    reg_check(8'hC0, "R1 read");
    rst_n = 1'b1;

    // R2: field widths and stride
    reg_write(8'h00, 32'hFFFF_FFF0);
    reg_check(8'h00, "R2 start width");
    reg_write(8'h04, 32'hFFFF_FFFF);
    reg_check(8'h04, "R2 ctrl width");
    reg_check(8'h44, "R2 stride");

    // R3: undefined offset
    reg_write(8'h48, 32'hDEAD_BEEF);
    reg_check(8'h48, "R3 read zero");
    reg_check(8'h40, "R3 start untouched");
    reg_check(8'h44, "R3 ctrl untouched");

    reg_write(8'h00, 32'h0000_0100);
    reg_write(8'h04, 32'h0);
    reg_write(8'h40, 32'h0000_2000);
    reg_write(8'h44, 32'h3);
    reg_write(8'h80, 32'h0000_0040);
    reg_write(8'hC0, 32'h7FFF_FFFF);
    reg_write(8'hC4, 32'h2);

    // R4: load when zero, no reload when non-zero
    cycle(0, 1'b1, 1'b0, 2'b00, 1'b0, "R4 load");
    cycle(0, 1'b1, 1'b0, 2'b00, 1'b0, "R4 no reload");
    // R6: increment by size, including reserved code
    for (int s = 0; s < 4; s++) cycle(0, 1'b0, 1'b1, 2'(s), 1'b0, "R6 incr");

    // R7: fixed single
    cycle(1, 1'b1, 1'b0, 2'b10, 1'b0, "R4 load ch1");
    repeat (2) cycle(1, 1'b0, 1'b1, 2'b10, 1'b0, "R7 fixed single");
    // R8: fixed burst walks then restores
    repeat (8) cycle(1, 1'b0, 1'b1, 2'b01, 1'b1, "R8 fixed burst");

    // R9: incrementing bursts continue
    cycle(2, 1'b1, 1'b0, 2'b10, 1'b1, "R4 load ch2");
    repeat (8) cycle(2, 1'b0, 1'b1, 2'b10, 1'b1, "R9 incr burst");

    // R4 priority over beat, R6 wrap, then reload from zero
    cycle(3, 1'b1, 1'b1, 2'b00, 1'b0, "R4 load priority");
    cycle(3, 1'b0, 1'b1, 2'b00, 1'b0, "R6 wrap");
    cycle(3, 1'b1, 1'b0, 2'b00, 1'b0, "R4 reload");

    // R5: bus select per channel
    @(negedge clk); #1;
    check("R5 periph", 32'(src_on_periph), 32'b1010);
    reg_write(8'h44, 32'h1);
    @(negedge clk); #1;
    check("R5 periph update", 32'(src_on_periph), 32'b1000);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule